// File: doc/BRIEF.md
# Mergeable Multi-Pipeline Display FIFO

This block buffers pixel words between a memory fetch engine and three display pipelines. In split mode each pipeline owns one storage bank. Each bank has its own write side fed by fetch and its own read side drained by the pipeline. When the merge configuration bit is set, the three banks are chained into one FIFO three times as deep. That FIFO serves pipeline 0 alone, and pipelines 1 and 2 go idle. This gives a single plane extra tolerance against memory latency spikes.

Each pipeline reports its fill level and asks for more data through a fetch request with hysteresis, between a low and a high threshold. It also keeps sticky underflow and overflow flags, which are cleared by a one-cycle clear pulse. A read from an empty FIFO is what corrupts the picture. The flag records that this happened, and the output holds the last good word.

Top module: `pix_fifo_array`

## Requirements
- R1: After reset every level is 0, every `rd_data` lane is 0, all underflow and overflow flags are 0 and every fetch request is 0.
- R2: In split mode (`merge_en` 0) pipeline p's FIFO is independent of the others, keeps first-in first-out order and holds exactly DEPTH (256) words.
- R3: In merged mode (`merge_en` 1) pipeline 0's FIFO holds exactly 3*DEPTH (768) words and keeps first-in first-out order across all three banks.
- R4: In merged mode pipelines 1 and 2 ignore writes and reads: their level stays 0, their fetch request stays 0 and their underflow flag does not set.
- R5: A change of `merge_en` takes effect only on a clock edge where all `pipe_en` bits are 0. Such a change empties all three FIFOs. While any pipeline is enabled, a change is ignored and the FIFO contents are kept.
- R6: A read request on an enabled pipeline whose FIFO is empty leaves `rd_data` at its last value and the level at 0, and sets that pipeline's underflow flag.
- R7: A write on an enabled pipeline whose FIFO is full is dropped: the level stays unchanged and that pipeline's overflow flag sets.
- R8: A flag stays set until a one-cycle pulse on its clear input, where bit p clears pipeline p; a new event in the same cycle as its clear keeps the flag set.
- R9: An enabled pipeline's fetch request is 1 one cycle after its level is below `lo_thresh`, is 0 one cycle after its level reaches `hi_thresh` or more, and otherwise holds its value.
- R10: A pipeline whose `pipe_en` bit is 0 ignores writes and reads, and its fetch request is 0 one cycle later.
- R11: A read accepted at a clock edge presents the head word on that pipeline's `rd_data` lane right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| merge_en | input | 1 | 1 joins the three banks into one FIFO for pipeline 0 |
| pipe_en | input | 3 | Per-pipeline enable, bit p for pipeline p |
| lo_thresh | input | 10 | Level below which a fetch request starts |
| hi_thresh | input | 10 | Level at or above which a fetch request stops |
| wr_valid | input | 3 | Write strobe from fetch, bit p for pipeline p |
| wr_data | input | 96 | Write words, lane p at bits [32p+31:32p] |
| rd_req | input | 3 | Read strobe from each pipeline |
| rd_data | output | 96 | Read words, lane p at bits [32p+31:32p] |
| level | output | 30 | Fill level, pipeline p at bits [10p+9:10p] |
| fetch_req | output | 3 | Per-pipeline request for more data |
| underflow | output | 3 | Sticky read-while-empty flags |
| overflow | output | 3 | Sticky write-while-full flags |
| udf_clr | input | 3 | Clear pulse for the underflow flags |
| ovf_clr | input | 3 | Clear pulse for the overflow flags |

## Verification
The embedded properties assume that reset is held low for at least one clock edge before any traffic. They also assume that `lo_thresh` does not exceed `hi_thresh`, so the fetch hysteresis has a defined band. The stimulus keeps both conditions: it sets the thresholds to 4 and 8 before releasing reset and never changes them. It also toggles `merge_en` only at a time it chooses, first with pipelines enabled and then with all of them disabled, so that both the locked and the accepted switch are exercised.

// File: rtl/pix_fifo_pkg.sv
// Package: shared types and constants for the mergeable display FIFO.
// Assumes: exactly three pipelines share the storage.
package pix_fifo_pkg;

    localparam int unsigned NUM_PIPES = 3;

    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_MERGED = 1'b1
    } fifo_mode_e;

endpackage

// File: rtl/pix_fifo_bank.sv
// Module: one storage bank, a simple dual-port array.
// It writes synchronously and reads combinationally.
// Assumes: the caller never writes and reads the same entry in a way that needs
// write-through; contents are not reset.
module pix_fifo_bank #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store a word when the write enable is high.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word without a register stage.
    assign rdata = mem[raddr];

endmodule

// File: rtl/pix_fifo_ctrl.sv
// Module: pointer, level and sticky-flag control for one logical FIFO.
// The capacity is an input, so one instance can serve 256 or 768 entries.
// Assumes: cap only changes in the cycle that flush is high.
module pix_fifo_ctrl #(
    parameter int unsigned LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          active,
    input  logic [LW-1:0] cap,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          udf_clr,
    input  logic          ovf_clr,
    output logic [LW-1:0] wptr,
    output logic [LW-1:0] rptr,
    output logic          wr_go,
    output logic          rd_go,
    output logic [LW-1:0] level,
    output logic          udf,
    output logic          ovf
);

    logic is_empty;
    logic is_full;
    logic udf_evt;
    logic ovf_evt;
    logic [LW-1:0] wptr_inc;
    logic [LW-1:0] rptr_inc;

    // Decode occupancy and accepted transfers.
    always_comb begin
        is_empty = (level == '0);
        is_full  = (level >= cap);
        wr_go    = active && wr_req && !is_full;
        rd_go    = active && rd_req && !is_empty;
        udf_evt  = active && rd_req && is_empty;
        ovf_evt  = active && wr_req && is_full;
        wptr_inc = (wptr == cap - LW'(1)) ? '0 : wptr + LW'(1);
        rptr_inc = (rptr == cap - LW'(1)) ? '0 : rptr + LW'(1);
    end

    // Advance pointers and level; flush empties the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_go) begin
                wptr <= wptr_inc;
            end
            if (rd_go) begin
                rptr <= rptr_inc;
            end
            if (wr_go && !rd_go) begin
                level <= level + LW'(1);
            end else if (rd_go && !wr_go) begin
                level <= level - LW'(1);
            end
        end
    end

    // Sticky underflow flag: a new event wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            udf <= 1'b0;
        end else if (udf_evt) begin
            udf <= 1'b1;
        end else if (udf_clr) begin
            udf <= 1'b0;
        end
    end

    // Sticky overflow flag: a new event wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (ovf_evt) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) level <= cap) else $error("level above capacity"); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (active && wr_req && !rd_req && level == cap && !flush) |=> level == $past(level)) else $error("write accepted when full"); // R7
    AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n) (active && rd_req && level == '0) |=> udf) else $error("underflow not flagged"); // R6
    AST_UDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (udf && !udf_clr) |=> udf) else $error("underflow flag lost"); // R8
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !ovf_clr) |=> ovf) else $error("overflow flag lost"); // R8

endmodule

// File: rtl/pix_fifo_fetch.sv
// Module: fetch request with hysteresis between two level thresholds.
// Assumes: lo <= hi; the request is dropped as soon as the pipeline goes idle.
module pix_fifo_fetch #(
    parameter int unsigned LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] lo,
    input  logic [LW-1:0] hi,
    output logic          fetch
);

    // Set below the low mark, clear at the high mark, hold in between.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fetch <= 1'b0;
        end else if (level < lo) begin
            fetch <= 1'b1;
        end else if (level >= hi) begin
            fetch <= 1'b0;
        end
    end

    AST_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !active |=> !fetch) else $error("fetch while idle"); // R10
    AST_FETCH_LOW: assert property (@(posedge clk) disable iff (!rst_n) (active && level < lo) |=> fetch) else $error("no fetch below low mark"); // R9

endmodule

// File: rtl/pix_fifo_array.sv
// Module: three display-pipeline FIFOs over three banks, mergeable into one
// triple-depth FIFO for pipeline 0.
// Assumes: DEPTH is a power of two; merge_en is changed by software only while
// all pipelines are disabled (other changes are ignored).
module pix_fifo_array
    import pix_fifo_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned NP   = NUM_PIPES,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(NP * DEPTH + 1),
    localparam int unsigned BW   = LW - AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             merge_en,
    input  logic [NP-1:0]    pipe_en,
    input  logic [LW-1:0]    lo_thresh,
    input  logic [LW-1:0]    hi_thresh,
    input  logic [NP-1:0]    wr_valid,
    input  logic [NP*DW-1:0] wr_data,
    input  logic [NP-1:0]    rd_req,
    output logic [NP*DW-1:0] rd_data,
    output logic [NP*LW-1:0] level,
    output logic [NP-1:0]    fetch_req,
    output logic [NP-1:0]    underflow,
    output logic [NP-1:0]    overflow,
    input  logic [NP-1:0]    udf_clr,
    input  logic [NP-1:0]    ovf_clr
);

    fifo_mode_e mode_q;
    logic       flush;
    logic       merged;

    logic [LW-1:0] wptr       [NP];
    logic [LW-1:0] rptr       [NP];
    logic [LW-1:0] lvl        [NP];
    logic [DW-1:0] bank_rdata [NP];
    logic [DW-1:0] pipe_rdata [NP];
    logic [NP-1:0] wr_go;
    logic [NP-1:0] rd_go;
    logic [NP-1:0] active;
    logic [BW-1:0] wbank0;
    logic [BW-1:0] rbank0;

    // Detect an accepted mode change; only legal while every pipeline is off.
    assign flush  = (pipe_en == '0) && (fifo_mode_e'(merge_en) != mode_q);
    assign merged = (mode_q == MODE_MERGED);
    assign wbank0 = wptr[0][LW-1:AW];
    assign rbank0 = rptr[0][LW-1:AW];

    // Latch the mode; held while any pipeline is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SPLIT;
        end else if (pipe_en == '0) begin
            mode_q <= fifo_mode_e'(merge_en);
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_pipe
        logic [LW-1:0] cap_p;
        logic [DW-1:0] rd_q;

        // A pipeline works when enabled, and in merged mode only pipeline 0.
        assign active[p] = pipe_en[p] && (!merged || p == 0);
        assign cap_p     = (merged && p == 0) ? LW'(NP * DEPTH) : LW'(DEPTH);

        pix_fifo_ctrl #(.LW(LW)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .active  (active[p]),
            .cap     (cap_p),
            .wr_req  (wr_valid[p]),
            .rd_req  (rd_req[p]),
            .udf_clr (udf_clr[p]),
            .ovf_clr (ovf_clr[p]),
            .wptr    (wptr[p]),
            .rptr    (rptr[p]),
            .wr_go   (wr_go[p]),
            .rd_go   (rd_go[p]),
            .level   (lvl[p]),
            .udf     (underflow[p]),
            .ovf     (overflow[p])
        );

        pix_fifo_fetch #(.LW(LW)) u_fetch (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (active[p]),
            .level  (lvl[p]),
            .lo     (lo_thresh),
            .hi     (hi_thresh),
            .fetch  (fetch_req[p])
        );

        // Select the head word: own bank when split, pointer-chosen bank when merged.
        always_comb begin
            pipe_rdata[p] = bank_rdata[p];
            if (merged && p == 0) begin
                for (int b = 0; b < NP; b++) begin
                    if (rbank0 == BW'(b)) begin
                        pipe_rdata[p] = bank_rdata[b];
                    end
                end
            end
        end

        // Register the popped word; hold it on an empty read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (rd_go[p]) begin
                rd_q <= pipe_rdata[p];
            end
        end

        assign rd_data[p*DW +: DW] = rd_q;
        assign level[p*LW +: LW]   = lvl[p];

        if (p != 0) begin : g_idle_chk
            AST_MERGED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) merged |-> (lvl[p] == '0 && !fetch_req[p])) else $error("idle pipeline busy in merged mode"); // R4
        end
    end

    for (genvar b = 0; b < NP; b++) begin : g_bank
        logic          we_b;
        logic [AW-1:0] waddr_b;
        logic [AW-1:0] raddr_b;
        logic [DW-1:0] wdata_b;

        // Route the write and read ports of this bank by mode.
        always_comb begin
            if (merged) begin
                we_b    = wr_go[0] && (wbank0 == BW'(b));
                waddr_b = wptr[0][AW-1:0];
                raddr_b = rptr[0][AW-1:0];
                wdata_b = wr_data[0 +: DW];
            end else begin
                we_b    = wr_go[b];
                waddr_b = wptr[b][AW-1:0];
                raddr_b = rptr[b][AW-1:0];
                wdata_b = wr_data[b*DW +: DW];
            end
        end

        pix_fifo_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (we_b),
            .waddr (waddr_b),
            .wdata (wdata_b),
            .raddr (raddr_b),
            .rdata (bank_rdata[b])
        );
    end

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (pipe_en != '0) |=> $stable(mode_q)) else $error("mode changed while enabled"); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (level == '0)) else $error("mode change left data"); // R5

endmodule

// File: tb/pix_fifo_array_bench.sv
module pix_fifo_array_bench;

    localparam int DW = 32;
    localparam int LW = 10;
    localparam int NP = 3;
    localparam int DEPTH = 256;
    localparam int NV = 8;

    // Vector: [17:15] write mask, [14:12] read mask, then expected levels of pipes 0,1,2.
    localparam logic [17:0] VEC [NV] = '{
        {3'b111, 3'b000, 4'd1, 4'd1, 4'd1},
        {3'b011, 3'b000, 4'd2, 4'd2, 4'd1},
        {3'b001, 3'b100, 4'd3, 4'd2, 4'd0},
        {3'b000, 3'b011, 4'd2, 4'd1, 4'd0},
        {3'b110, 3'b010, 4'd2, 4'd1, 4'd1},
        {3'b111, 3'b111, 4'd2, 4'd1, 4'd1},
        {3'b000, 3'b111, 4'd1, 4'd0, 4'd0},
        {3'b000, 3'b001, 4'd0, 4'd0, 4'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             merge_en = 1'b0;
    logic [NP-1:0]    pipe_en = '0;
    logic [LW-1:0]    lo_thresh = LW'(4);
    logic [LW-1:0]    hi_thresh = LW'(8);
    logic [NP-1:0]    wr_valid = '0;
    logic [NP*DW-1:0] wr_data = '0;
    logic [NP-1:0]    rd_req = '0;
    logic [NP*DW-1:0] rd_data;
    logic [NP*LW-1:0] level;
    logic [NP-1:0]    fetch_req;
    logic [NP-1:0]    underflow;
    logic [NP-1:0]    overflow;
    logic [NP-1:0]    udf_clr = '0;
    logic [NP-1:0]    ovf_clr = '0;

    int checks = 0;
    int errors = 0;
    int wcnt [NP];
    int rcnt [NP];
    bit done = 1'b0;

    always #10 clk = ~clk;

    pix_fifo_array u_pix_fifo_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .merge_en  (merge_en),
        .pipe_en   (pipe_en),
        .lo_thresh (lo_thresh),
        .hi_thresh (hi_thresh),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .level     (level),
        .fetch_req (fetch_req),
        .underflow (underflow),
        .overflow  (overflow),
        .udf_clr   (udf_clr),
        .ovf_clr   (ovf_clr)
    );

    function automatic logic [DW-1:0] dat(input int p, input int n);
        return {8'(p + 1), 24'(n)};
    endfunction

    function automatic logic [LW-1:0] lvl(input int p);
        return level[p*LW +: LW];
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input int p, input bit accepted);
        wr_valid[p] = 1'b1;
        wr_data[p*DW +: DW] = dat(p, wcnt[p]);
        cyc();
        wr_valid[p] = 1'b0;
        if (accepted) wcnt[p]++;
    endtask

    task automatic pop(input int p, input string req);
        rd_req[p] = 1'b1;
        cyc();
        rd_req[p] = 1'b0;
        chk(req, "read word", 64'(rd_data[p*DW +: DW]), 64'(dat(p, rcnt[p])));
        rcnt[p]++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] last;
        for (int p = 0; p < NP; p++) begin
            wcnt[p] = 0;
            rcnt[p] = 0;
        end
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "levels", 64'(level), 64'(0));
        chk("R1", "rd_data", 64'(rd_data), 64'(0));
        chk("R1", "flags", 64'({underflow, overflow}), 64'(0));
        chk("R1", "fetch", 64'(fetch_req), 64'(0));

        pipe_en = 3'b111;
        cyc();
        // R9: empty enabled pipelines request data one cycle later
        chk("R9", "fetch rise", 64'(fetch_req), 64'(3'b111));

        // R2 R11: table of split-mode traffic
        for (int i = 0; i < NV; i++) begin
            wr_valid = VEC[i][17:15];
            rd_req = VEC[i][14:12];
            for (int p = 0; p < NP; p++) wr_data[p*DW +: DW] = dat(p, wcnt[p]);
            cyc();
            for (int p = 0; p < NP; p++) begin
                if (rd_req[p]) begin
                    chk("R11", "table read", 64'(rd_data[p*DW +: DW]), 64'(dat(p, rcnt[p])));
                    rcnt[p]++;
                end
                if (wr_valid[p]) wcnt[p]++;
            end
            wr_valid = '0;
            rd_req = '0;
            chk("R2", "table levels", 64'(level), 64'({6'(VEC[i][3:0]), 6'(VEC[i][7:4]), 6'(VEC[i][11:8])}) & 64'h0 | 64'({LW'(VEC[i][3:0]), LW'(VEC[i][7:4]), LW'(VEC[i][11:8])}));
        end
        chk("R6", "no underflow in table", 64'(underflow), 64'(0));

        // R2 R7: fill pipeline 1 to its depth, then one dropped write
        for (int k = 0; k < DEPTH; k++) push(1, 1'b1);
        chk("R2", "pipe1 full level", 64'(lvl(1)), 64'(DEPTH));
        chk("R7", "no overflow at depth", 64'(overflow[1]), 64'(0));
        push(1, 1'b0);
        chk("R7", "level after dropped write", 64'(lvl(1)), 64'(DEPTH));
        chk("R7", "overflow flag", 64'(overflow[1]), 64'(1));
        chk("R2", "pipe0 untouched", 64'(lvl(0)), 64'(0));
        for (int k = 0; k < DEPTH; k++) pop(1, "R2");
        last = dat(1, rcnt[1] - 1);

        // R6: read while empty
        rd_req[1] = 1'b1;
        cyc();
        rd_req[1] = 1'b0;
        chk("R6", "held word", 64'(rd_data[DW +: DW]), 64'(last));
        chk("R6", "level stays 0", 64'(lvl(1)), 64'(0));
        chk("R6", "underflow flag", 64'(underflow[1]), 64'(1));
        cyc();
        chk("R8", "underflow sticky", 64'(underflow[1]), 64'(1));
        udf_clr[1] = 1'b1;
        ovf_clr[1] = 1'b1;
        cyc();
        udf_clr = '0;
        ovf_clr = '0;
        chk("R8", "underflow cleared", 64'(underflow[1]), 64'(0));
        chk("R8", "overflow cleared", 64'(overflow[1]), 64'(0));

        // R9: hysteresis on pipeline 2 with lo=4, hi=8
        chk("R9", "fetch while empty", 64'(fetch_req[2]), 64'(1));
        for (int k = 0; k < 8; k++) push(2, 1'b1);
        chk("R9", "fetch one cycle after reaching hi", 64'(fetch_req[2]), 64'(1));
        cyc();
        chk("R9", "fetch drops at hi", 64'(fetch_req[2]), 64'(0));
        for (int k = 0; k < 4; k++) pop(2, "R11");
        cyc();
        chk("R9", "fetch held at lo", 64'(fetch_req[2]), 64'(0));
        pop(2, "R11");
        cyc();
        chk("R9", "fetch rises below lo", 64'(fetch_req[2]), 64'(1));
        for (int k = 0; k < 3; k++) pop(2, "R11");

        // R10: disabled pipeline ignores traffic
        pipe_en = 3'b011;
        wr_valid[2] = 1'b1;
        rd_req[2] = 1'b1;
        cyc();
        cyc();
        wr_valid = '0;
        rd_req = '0;
        chk("R10", "disabled level", 64'(lvl(2)), 64'(0));
        chk("R10", "disabled fetch", 64'(fetch_req[2]), 64'(0));
        chk("R10", "disabled no underflow", 64'(underflow[2]), 64'(0));

        // R5: merge change ignored while enabled
        push(0, 1'b1);
        merge_en = 1'b1;
        cyc();
        push(1, 1'b1);
        chk("R5", "pipe0 kept", 64'(lvl(0)), 64'(1));
        chk("R5", "still split, pipe1 accepts", 64'(lvl(1)), 64'(1));
        pipe_en = '0;
        cyc();
        chk("R5", "change empties all", 64'(level), 64'(0));
        for (int p = 0; p < NP; p++) begin
            wcnt[p] = 0;
            rcnt[p] = 0;
        end

        // R3 R4: merged FIFO
        pipe_en = 3'b111;
        wr_valid[1] = 1'b1;
        for (int k = 0; k < NP * DEPTH; k++) push(0, 1'b1);
        wr_valid[1] = 1'b0;
        chk("R3", "merged full level", 64'(lvl(0)), 64'(NP * DEPTH));
        chk("R4", "pipe1 ignores writes", 64'(lvl(1)), 64'(0));
        chk("R4", "pipe1 no fetch", 64'(fetch_req[1]), 64'(0));
        chk("R7", "no overflow at merged depth", 64'(overflow[0]), 64'(0));
        push(0, 1'b0);
        chk("R7", "merged drop level", 64'(lvl(0)), 64'(NP * DEPTH));
        chk("R7", "merged overflow", 64'(overflow[0]), 64'(1));
        for (int k = 0; k < NP * DEPTH; k++) pop(0, "R3");
        chk("R3", "merged drained", 64'(lvl(0)), 64'(0));
        rd_req[2] = 1'b1;
        cyc();
        rd_req[2] = 1'b0;
        chk("R4", "pipe2 read ignored", 64'(underflow[2]), 64'(0));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule